// File: doc/BRIEF.md
# Modem Control and Status Unit with Internal Loopback

This unit holds the modem control byte of a 16550-style serial port and builds its modem status byte. Four control bits drive the active-low handshake outputs (data-terminal-ready, request-to-send and two general-purpose outputs). Four active-low handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) are synchronised. The unit shows them as active-high levels and latches any change into sticky delta flags. A read strobe from the register decoder clears the flags, and a single flag tells the interrupt logic that at least one of them is set.

A fifth control bit selects internal loopback. In loopback each control bit is routed onto one status input. The external handshake inputs are then ignored and the outputs are parked at their inactive high level. Software can use this to exercise the status path, the delta flags and the interrupt without anything connected. A change in the status view caused by entering or leaving loopback is reported like any other change.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset all four control outputs are high, the status byte reads 0x00 while the inputs are idle (high), and the change flag is low.
- R2: Outside loopback, control bits 0, 1, 2 and 3 drive data-terminal-ready, request-to-send, general output 1 and general output 2 low when set and high when clear, one cycle after the write.
- R3: Status bits 4, 5, 6 and 7 show the complement of the clear-to-send, data-set-ready, ring and carrier inputs. A pad change becomes visible after the third rising clock edge and is not visible after the second.
- R4: Status bits 0, 1 and 3 are set by any change, in either direction, of the clear-to-send, data-set-ready and carrier status levels.
- R5: Status bit 2 is set only when the ring input goes from low to high (status bit 6 falling); the opposite edge sets no flag.
- R6: A status read clears bits 3:0 at the read edge; without a read a set flag stays set; the change flag output is high exactly while any of bits 3:0 is set.
- R7: A change that arrives at the same edge as a status read leaves its flag set after the read.
- R8: With control bit 4 set, status bits 4, 5, 6 and 7 follow control bits 1, 0, 2 and 3, one cycle after the write, and changes on the external inputs have no effect.
- R9: While control bit 4 is set, all four control outputs are held high regardless of control bits 3:0.
- R10: Entering or leaving loopback sets the delta flags for every status level that changes as a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Write strobe for the control byte |
| ctl_wr_data | input | 5 | Control value: bit0 terminal-ready, bit1 request-to-send, bit2 output 1, bit3 output 2, bit4 loopback |
| stat_rd | input | 1 | Status read strobe; clears delta flags |
| cts_n_i | input | 1 | Clear-to-send input, active low |
| dsr_n_i | input | 1 | Data-set-ready input, active low |
| ri_n_i | input | 1 | Ring indicator input, active low |
| dcd_n_i | input | 1 | Carrier detect input, active low |
| dtr_n_o | output | 1 | Data-terminal-ready output, active low |
| rts_n_o | output | 1 | Request-to-send output, active low |
| out1_n_o | output | 1 | General output 1, active low |
| out2_n_o | output | 1 | General output 2, active low |
| stat_q | output | 8 | Status byte: bits 3:0 delta flags, bits 7:4 active-high levels |
| modem_irq | output | 1 | High while any delta flag is set |

## Verification
On every cycle the checker confirms that a delta flag can only rise together with a matching change of its status level, that ring uses only the falling status edge, and that set flags persist until a read. It also checks that loopback parks the outputs high and that a settled loopback status mirrors the permuted control bits. The bench scenarios cover what needs a sequence: the exact synchroniser latency, the values returned by a read followed by the clear, a read colliding with a fresh change, isolation from the external inputs in loopback, and the deltas produced on loopback entry and exit.

// File: rtl/modem_pkg.sv
package modem_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Control byte layout (decoded by the pad and loopback logic)
  localparam int CTL_W    = 5;
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;

  // Handshake line vector order; matches delta bit order and status level order
  localparam int LINE_W  = 4;
  localparam int LN_CTS  = 0;
  localparam int LN_DSR  = 1;
  localparam int LN_RI   = 2;
  localparam int LN_DCD  = 3;

  localparam int STAT_W  = 2 * LINE_W;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= IDLE;
          else     stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= IDLE;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [LINE_W-1:0] pad_n_q,    // {out2, out1, rts, dtr}
  output logic [LINE_W-1:0] loop_lines  // active-high lines seen in loopback
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      pad_n_q <= '1;
    end else if (wr_en) begin
      ctl_q <= wr_data;
      if (wr_data[CTL_LOOP]) pad_n_q <= '1;
      else                   pad_n_q <= ~wr_data[LINE_W-1:0];
    end
  end

  // Each control bit feeds one status line when looped back
  always_comb begin
    loop_lines         = '0;
    loop_lines[LN_CTS] = ctl_q[CTL_RTS];
    loop_lines[LN_DSR] = ctl_q[CTL_DTR];
    loop_lines[LN_RI]  = ctl_q[CTL_OUT1];
    loop_lines[LN_DCD] = ctl_q[CTL_OUT2];
  end
endmodule

// File: rtl/modem_delta.sv
module modem_delta
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] lines_i,   // active-high current levels
  input  logic              clr_i,     // status read
  output logic [LINE_W-1:0] lines_q,
  output logic [LINE_W-1:0] delta_q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LINE_W-1:0] evt;

  genvar i;
  generate
    for (i = 0; i < LINE_W; i++) begin : g_evt
      if (i == LN_RI) begin : g_trailing
        // ring input rising on the pad = active-high level falling
        assign evt[i] = lines_q[i] & ~lines_i[i];
      end else begin : g_any
        assign evt[i] = lines_q[i] ^ lines_i[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      delta_q <= '0;
    end else begin
      lines_q <= lines_i;
      delta_q <= (delta_q & {LINE_W{~clr_i}}) | evt;
    end
  end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  input  logic              stat_rd,
  input  logic              cts_n_i,
  input  logic              dsr_n_i,
  input  logic              ri_n_i,
  input  logic              dcd_n_i,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  output logic              out1_n_o,
  output logic              out2_n_o,
  output logic [STAT_W-1:0] stat_q,
  output logic              modem_irq
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LINE_W-1:0] pad_in_n, pad_sync_n, ext_lines, loop_lines, cur_lines;
  logic [LINE_W-1:0] lines_q, delta_q, pad_n_q;
  logic [CTL_W-1:0]  ctl_q;

  always_comb begin
    pad_in_n         = '1;
    pad_in_n[LN_CTS] = cts_n_i;
    pad_in_n[LN_DSR] = dsr_n_i;
    pad_in_n[LN_RI]  = ri_n_i;
    pad_in_n[LN_DCD] = dcd_n_i;
  end

  modem_sync #(.W(LINE_W), .STAGES(SYNC_STAGES), .IDLE('1)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pad_in_n),
    .sync_o  (pad_sync_n)
  );

  modem_ctl_reg i_ctl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ctl_wr_en),
    .wr_data    (ctl_wr_data),
    .ctl_q      (ctl_q),
    .pad_n_q    (pad_n_q),
    .loop_lines (loop_lines)
  );

  assign ext_lines = ~pad_sync_n;
  assign cur_lines = ctl_q[CTL_LOOP] ? loop_lines : ext_lines;

  modem_delta i_delta (
    .clk     (clk),
    .rst     (rst),
    .lines_i (cur_lines),
    .clr_i   (stat_rd),
    .lines_q (lines_q),
    .delta_q (delta_q)
  );

  assign dtr_n_o   = pad_n_q[CTL_DTR];
  assign rts_n_o   = pad_n_q[CTL_RTS];
  assign out1_n_o  = pad_n_q[CTL_OUT1];
  assign out2_n_o  = pad_n_q[CTL_OUT2];
  assign stat_q    = {lines_q, delta_q};
  assign modem_irq = |delta_q;
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] ctl,
  input logic [3:0] pads_n,
  input logic       stat_rd,
  input logic [7:0] stat
);
  timeunit 1ns;
  timeprecision 1ps;

  // R9
  loop_pads_high_chk: assert property (@(posedge clk) disable iff (rst)
    ctl[4] |-> (pads_n == 4'hF));

  // R4
  cts_delta_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[0]) |-> (stat[4] != $past(stat[4])));

  // R4
  dsr_delta_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[1]) |-> (stat[5] != $past(stat[5])));

  // R4
  dcd_delta_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[3]) |-> (stat[7] != $past(stat[7])));

  // R5
  ri_trailing_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[2]) |-> $fell(stat[6]));

  // R6
  delta_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat_rd && (stat[3:0] != 4'h0)) |=> ((stat[3:0] & $past(stat[3:0])) == $past(stat[3:0])));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (!stat[0] || (stat[4] != $past(stat[4]))));

  // R8
  loop_map_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl[4] && $stable(ctl)) |-> (stat[7:4] == {ctl[3], ctl[2], ctl[0], ctl[1]}));
endmodule

bind modem_ctl_stat modem_ctl_stat_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .ctl     (ctl_q),
  .pads_n  (pad_n_q),
  .stat_rd (stat_rd),
  .stat    (stat_q)
);

// File: tb/test_modem_ctl_stat.sv
module test_modem_ctl_stat;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr_en = 1'b0;
  logic [4:0] ctl_wr_data = '0;
  logic       stat_rd = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       dtr_n, rts_n, out1_n, out2_n, irq;
  logic [7:0] stat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  modem_ctl_stat i_modem_ctl_stat (
    .clk(clk), .rst(rst),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .stat_rd(stat_rd),
    .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .dcd_n_i(dcd_n),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .out1_n_o(out1_n), .out2_n_o(out2_n),
    .stat_q(stat), .modem_irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    stat_rd = 1'b1; v = stat;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  function automatic logic [3:0] pads();
    return {out2_n, out1_n, rts_n, dtr_n};
  endfunction

  task automatic t_reset();
    chk("R1 pads", pads(), 4'hF);
    chk("R1 stat", stat, 8'h00);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_ctl_outputs();
    wr_ctl(5'b0_0101);
    chk("R2 pads 0101", pads(), 4'b1010);
    wr_ctl(5'b0_1010);
    chk("R2 pads 1010", pads(), 4'b0101);
    wr_ctl(5'b0_0000);
    chk("R2 pads idle", pads(), 4'hF);
  endtask

  task automatic t_cts_latency_and_clear();
    logic [7:0] v;
    cts_n = 1'b0;
    tick(2);
    chk("R3 not yet visible", stat, 8'h00);
    tick(1);
    chk("R3 cts level + R4 delta", stat, 8'h11);
    chk("R6 irq high", irq, 1'b1);
    tick(2);
    chk("R6 flag held", stat, 8'h11);
    rd_stat(v);
    chk("R6 read value", v, 8'h11);
    chk("R6 cleared", stat, 8'h10);
    chk("R6 irq low", irq, 1'b0);
    cts_n = 1'b1;
    tick(3);
    chk("R4 cts falling delta", stat, 8'h01);
    rd_stat(v);
    chk("R6 cleared again", stat, 8'h00);
  endtask

  task automatic t_dsr_dcd();
    logic [7:0] v;
    dsr_n = 1'b0; dcd_n = 1'b0;
    tick(3);
    chk("R3 R4 dsr dcd on", stat, 8'hAA);
    rd_stat(v);
    chk("R6 dsr dcd clear", stat, 8'hA0);
    dsr_n = 1'b1; dcd_n = 1'b1;
    tick(3);
    chk("R4 dsr dcd off", stat, 8'h0A);
    rd_stat(v);
    chk("R6 clear", stat, 8'h00);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    ri_n = 1'b0;
    tick(3);
    chk("R5 leading edge no flag", stat, 8'h40);
    chk("R5 irq low", irq, 1'b0);
    ri_n = 1'b1;
    tick(3);
    chk("R5 trailing edge flag", stat, 8'h04);
    chk("R5 irq high", irq, 1'b1);
    rd_stat(v);
    chk("R6 clear", stat, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    cts_n = 1'b0;
    tick(3);
    chk("R4 setup", stat, 8'h11);
    cts_n = 1'b1;
    tick(2);
    rd_stat(v);
    chk("R7 read value", v, 8'h11);
    chk("R7 flag survives read", stat, 8'h01);
    rd_stat(v);
    chk("R7 later read clears", stat, 8'h00);
  endtask

  task automatic t_loopback();
    logic [7:0] v;
    wr_ctl(5'b1_0000);
    tick(1);
    chk("R10 no change no delta", stat, 8'h00);
    chk("R9 pads high", pads(), 4'hF);
    wr_ctl(5'b1_0010);
    chk("R9 pads high with rts bit", pads(), 4'hF);
    tick(1);
    chk("R8 rts to cts", stat, 8'h11);
    dsr_n = 1'b0; cts_n = 1'b0;
    tick(3);
    chk("R8 external inputs ignored", stat, 8'h11);
    dsr_n = 1'b1; cts_n = 1'b1;
    tick(3);
    chk("R8 external inputs ignored 2", stat, 8'h11);
    rd_stat(v);
    wr_ctl(5'b1_0001);
    tick(1);
    chk("R8 dtr to dsr", stat, 8'h23);
    rd_stat(v);
    wr_ctl(5'b1_0100);
    tick(1);
    chk("R8 out1 to ring", stat, 8'h42);
    rd_stat(v);
    wr_ctl(5'b1_1000);
    tick(1);
    chk("R8 out2 to dcd + R5 ring trailing", stat, 8'h8C);
    chk("R9 pads high with out2 bit", pads(), 4'hF);
    rd_stat(v);
    wr_ctl(5'b0_0000);
    tick(1);
    chk("R10 exit delta", stat, 8'h08);
    rd_stat(v);
    chk("R6 clear", stat, 8'h00);
  endtask

  task automatic t_loop_entry();
    logic [7:0] v;
    wr_ctl(5'b1_0011);
    chk("R9 pads high on entry", pads(), 4'hF);
    tick(1);
    chk("R10 entry deltas", stat, 8'h33);
    rd_stat(v);
    wr_ctl(5'b0_0011);
    chk("R2 pads after exit", pads(), 4'b1100);
    tick(1);
    chk("R10 exit deltas", stat, 8'h03);
    rd_stat(v);
    chk("R6 clear", stat, 8'h00);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_ctl_outputs();
    t_cts_latency_and_clear();
    t_dsr_dcd();
    t_ring();
    t_collision();
    t_loopback();
    t_loop_entry();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule